// File: doc/BRIEF.md
# Demultiplexing Bus Glue with Segment Display Port

This block sits between an 8-bit microcontroller's external bus and two devices on that bus: a 32 KB static RAM and a seven-segment display. The processor puts the low address byte on a shared address/data port while its address-latch strobe is high, and later uses the same pins for data. The block holds that low byte in a latch that follows the port while the strobe is high and keeps it after the strobe falls. It then joins the held byte with the high-address port to form a 16-bit address.

From that address and the processor's strobes (program-store enable, read and write, all active low), the block drives chip select, output enable and write enable for the SRAM. The SRAM sits in the lower half of the address space and serves both instruction fetches and data accesses. One data address, 0x7F55, is also decoded as a write-only 8-bit output register that drives the segments. It keeps each written pattern until the next write to that address, so software can show a pattern, blank it with zero, and then show the next one.

All sequential state runs on a fast system clock that samples the bus strobes. The address latch is transparent through a combinational bypass while the latch strobe is high.

Top module: `bus_glue`

## Requirements
- R1: While `ale` is high, `addr[7:0]` equals `ad_in` in the same cycle (the low latch is transparent).
- R2: While `ale` is low, `addr[7:0]` holds the `ad_in` value sampled at the last rising clock edge at which `ale` was high, whatever `ad_in` does.
- R3: `addr[15:8]` always equals `a_hi`.
- R4: `sram_ce_n` is low exactly when `addr[15]` is 0 (addresses 0x0000 to 0x7FFF).
- R5: `sram_oe_n` is low exactly when `wr_n` is high, `addr[15]` is 0 and at least one of `psen_n` or `rd_n` is low. It is never low while `wr_n` is low.
- R6: `sram_we_n` is low exactly when `wr_n` is low and `addr[15]` is 0.
- R7: At the first rising clock edge that sees `wr_n` high after it was low, the display register loads the `ad_in` byte sampled at the last edge during the low strobe. This happens only if `addr` was exactly 0x7F55 at that sample.
- R8: Write strobes at any other address, for example 0x7F54, 0x7F56 or 0xFF55, leave the display register unchanged.
- R9: The display register drives the outputs as follows: register bit 0 drives `seg[0]` (segment a), and so on up to bit 6 on `seg[6]` (segment g). Bit 7 drives `seg_spare`.
- R10: Reset clears the display register to 0x00. After that, it keeps its value until the next qualifying write. Read or program-fetch strobes at 0x7F55 do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus strobes |
| rst_n | input | 1 | Active-low synchronous reset |
| ale | input | 1 | Address latch strobe, high during the address phase |
| psen_n | input | 1 | Program-store enable, active low |
| rd_n | input | 1 | External data read strobe, active low |
| wr_n | input | 1 | External data write strobe, active low |
| ad_in | input | 8 | Multiplexed low address / data port |
| a_hi | input | 8 | High address byte |
| addr | output | 16 | Demultiplexed address to the SRAM |
| sram_ce_n | output | 1 | SRAM chip select, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| seg | output | 7 | Segment drives a..g on bits 0..6 |
| seg_spare | output | 1 | Spare display register bit 7 |

## Verification
A stale or corrupted latch shows up at once as a wrong low byte on `addr` in the data phase. It also moves the SRAM selects and the port decode, so a write aimed at 0x7F55 lands in the wrong place or is lost. A wrong decode or a mis-captured data byte shows up one clock after the write strobe rises, as a wrong segment pattern. A spurious load shows up in the same way after a neighbouring-address write or a read. Because the register holds its value indefinitely, the bench reads it back after each scenario to catch any corruption that was left behind.

// File: rtl/bus_glue_pkg.sv
package bus_glue_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;
  localparam int SEG_W   = 7;
  localparam logic [ADDR_W-1:0] DISP_ADDR = 16'h7F55;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;

  // SRAM window: top address bit clear
  function automatic logic in_sram(input addr_t a);
    return (a[ADDR_W-1] == 1'b0);
  endfunction

  // Full 16-bit compare against the display port
  function automatic logic is_disp(input addr_t a, input addr_t port);
    return (a == port);
  endfunction

  // Output enable: a read or fetch strobe, inside the window, never during a write
  function automatic logic oe_active(input logic inwin, input logic psen_n,
                                     input logic rd_n, input logic wr_n);
    return inwin && wr_n && (!psen_n || !rd_n);
  endfunction
endpackage

// File: rtl/bus_addr_demux.sv
module bus_addr_demux
  import bus_glue_pkg::*;
#(
  parameter int LO_W = DATA_W,
  parameter int HI_W = ADDR_W - DATA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ale,
  input  logic [LO_W-1:0] ad_in,
  input  logic [HI_W-1:0] a_hi,
  output logic [LO_W+HI_W-1:0] addr,
  output logic [LO_W-1:0] lo_held
);
  logic [LO_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   lo_q <= '0;
    else if (ale) lo_q <= ad_in;
  end

  assign lo_held = lo_q;
  assign addr    = {a_hi, (ale ? ad_in : lo_q)};
endmodule

// File: rtl/bus_mem_select.sv
module bus_mem_select
  import bus_glue_pkg::*;
(
  input  addr_t addr,
  input  logic  psen_n,
  input  logic  rd_n,
  input  logic  wr_n,
  output logic  sram_ce_n,
  output logic  sram_oe_n,
  output logic  sram_we_n,
  output logic  win_hit
);
  assign win_hit   = in_sram(addr);
  assign sram_ce_n = !win_hit;
  assign sram_oe_n = !oe_active(win_hit, psen_n, rd_n, wr_n);
  assign sram_we_n = !(win_hit && !wr_n);
endmodule

// File: rtl/seg_port_reg.sv
module seg_port_reg
  import bus_glue_pkg::*;
#(
  parameter int W = DATA_W,
  parameter logic [ADDR_W-1:0] PORT = DISP_ADDR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_n,
  input  addr_t         addr,
  input  logic [W-1:0]  ad_in,
  output logic [W-1:0]  reg_q,
  output logic          wr_rise,
  output logic          samp_hit,
  output logic [W-1:0]  samp_data
);
  logic         wr_n_q;
  logic         hit_q;
  logic [W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_n_q <= 1'b1;
      hit_q  <= 1'b0;
      data_q <= '0;
    end else begin
      wr_n_q <= wr_n;
      if (!wr_n) begin
        hit_q  <= is_disp(addr, PORT);
        data_q <= ad_in;
      end
    end
  end

  assign wr_rise   = wr_n && !wr_n_q;
  assign samp_hit  = hit_q;
  assign samp_data = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                   reg_q <= '0;
    else if (wr_rise && hit_q)    reg_q <= data_q;
  end
endmodule

// File: rtl/bus_glue.sv
module bus_glue
  import bus_glue_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PORT_ADDR = DISP_ADDR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic              psen_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] ad_in,
  input  logic [DATA_W-1:0] a_hi,
  output logic [ADDR_W-1:0] addr,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [SEG_W-1:0]  seg,
  output logic              seg_spare
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [DATA_W-1:0] lo_held;
  logic [DATA_W-1:0] disp_q;
  logic [DATA_W-1:0] samp_data;
  logic              win_hit;
  logic              wr_rise;
  logic              samp_hit;

  bus_addr_demux #(.LO_W(DATA_W), .HI_W(HI_W)) u_demux (
    .clk(clk), .rst_n(rst_n), .ale(ale), .ad_in(ad_in), .a_hi(a_hi),
    .addr(addr), .lo_held(lo_held)
  );

  bus_mem_select u_sel (
    .addr(addr), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .win_hit(win_hit)
  );

  seg_port_reg #(.W(DATA_W), .PORT(PORT_ADDR)) u_port (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .addr(addr), .ad_in(ad_in),
    .reg_q(disp_q), .wr_rise(wr_rise), .samp_hit(samp_hit),
    .samp_data(samp_data)
  );

  assign seg       = disp_q[SEG_W-1:0];
  assign seg_spare = disp_q[DATA_W-1];
endmodule

// File: rtl/bus_glue_chk.sv
module bus_glue_chk
  import bus_glue_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ale,
  input logic              wr_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] lo_held,
  input logic              sram_ce_n,
  input logic              sram_oe_n,
  input logic              sram_we_n,
  input logic [SEG_W-1:0]  seg,
  input logic              seg_spare,
  input logic              wr_rise,
  input logic              samp_hit,
  input logic [DATA_W-1:0] samp_data
);
  // R2: low byte does not move while the latch strobe stays low
  a_r2_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && !$past(ale)) |-> $stable(addr[DATA_W-1:0]));

  // R2: held byte is what the address output shows when strobe is low
  a_r2_held_drives: assert property (@(posedge clk) disable iff (!rst_n)
    !ale |-> (addr[DATA_W-1:0] == lo_held));

  // R5: the bus is never driven by the SRAM during a write
  a_r5_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> sram_oe_n);

  // R5/R6: enables only inside the selected window
  a_r5_oe_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_oe_n || !sram_we_n) |-> !sram_ce_n);

  // R7: a qualifying rise loads the sampled byte
  a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && samp_hit) |=> ({seg_spare, seg} == $past(samp_data)));

  // R10: no rise, no change
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_n && $past(wr_n)) |=> $stable({seg_spare, seg}));
endmodule

bind bus_glue bus_glue_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .wr_n(wr_n), .addr(addr),
  .lo_held(lo_held), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
  .sram_we_n(sram_we_n), .seg(seg), .seg_spare(seg_spare),
  .wr_rise(wr_rise), .samp_hit(samp_hit), .samp_data(samp_data)
);

// File: tb/bus_glue_tb.sv
module bus_glue_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ale = 1'b0, psen_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0]  ad_in = 8'h00, a_hi = 8'h00;
  logic [15:0] addr;
  logic        sram_ce_n, sram_oe_n, sram_we_n;
  logic [6:0]  seg;
  logic        seg_spare;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_disp = 8'h00;

  always #2.5 clk = ~clk;

  bus_glue u_dut (
    .clk(clk), .rst_n(rst_n), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
    .wr_n(wr_n), .ad_in(ad_in), .a_hi(a_hi), .addr(addr),
    .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .seg(seg), .seg_spare(seg_spare)
  );

  task automatic check(input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_disp(input string req);
    check(req, {8'h00, seg_spare, seg}, {8'h00, exp_disp});
  endtask

  // Address phase: ale high, then falls; caller continues with data phase
  task automatic addr_phase(input logic [15:0] a);
    @(negedge clk);
    ale = 1'b1; ad_in = a[7:0]; a_hi = a[15:8];
    #1 check("R1", {8'h00, addr[7:0]}, {8'h00, a[7:0]});
    check("R3", {8'h00, addr[15:8]}, {8'h00, a[15:8]});
    @(negedge clk);
    ale = 1'b0;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    addr_phase(a);
    ad_in = d;
    #1 check("R2", addr, a);
    @(negedge clk);
    wr_n = 1'b0;
    #1 check("R6", {15'h0, sram_we_n}, {15'h0, a[15]});
    check("R5", {15'h0, sram_oe_n}, 16'h1);
    check("R4", {15'h0, sram_ce_n}, {15'h0, a[15]});
    @(negedge clk);
    @(negedge clk);
    wr_n = 1'b1;
    if (a == 16'h7F55) exp_disp = d;
    @(negedge clk);
    @(negedge clk);
    check_disp(a == 16'h7F55 ? "R7" : "R8");
  endtask

  task automatic bus_read(input logic [15:0] a, input logic use_psen);
    addr_phase(a);
    ad_in = 8'hA5;
    @(negedge clk);
    if (use_psen) psen_n = 1'b0; else rd_n = 1'b0;
    #1 check("R5", {15'h0, sram_oe_n}, {15'h0, a[15]});
    check("R2", addr, a);
    check("R6", {15'h0, sram_we_n}, 16'h1);
    @(negedge clk);
    psen_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    check_disp("R10");
  endtask

  task automatic t_reset;
    check_disp("R10");
    check("R5", {15'h0, sram_oe_n}, 16'h1);
  endtask

  task automatic t_latch_hold;
    addr_phase(16'h1234);
    for (int i = 0; i < 4; i++) begin
      ad_in = 8'h10 * i[7:0] + 8'h3;
      #1 check("R2", addr, 16'h1234);
      @(negedge clk);
    end
  endtask

  task automatic t_decode;
    bus_write(16'h7F55, 8'h3F);
    check("R9", {15'h0, seg[0]}, 16'h1);
    check("R9", {15'h0, seg[6]}, 16'h0);
    bus_write(16'h7F54, 8'h06);
    bus_write(16'h7F56, 8'h5B);
    bus_write(16'hFF55, 8'h4F);
    bus_write(16'h7E55, 8'h66);
    bus_write(16'h7F55, 8'hC0);
    check("R9", {15'h0, seg_spare}, 16'h1);
    check("R9", {9'h0, seg}, 16'h0040);
    bus_write(16'h7F55, 8'h00);
  endtask

  task automatic t_select;
    bus_read(16'h7FFF, 1'b0);
    bus_read(16'h8000, 1'b0);
    bus_read(16'h0000, 1'b1);
    bus_read(16'hC123, 1'b1);
    bus_write(16'h7F55, 8'h6D);
    bus_read(16'h7F55, 1'b0);
    bus_read(16'h7F55, 1'b1);
    repeat (20) @(negedge clk);
    check_disp("R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch_hold();
    t_decode();
    t_select();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule